// File: doc/BRIEF.md
# Synchronous Burst Static Memory (Flow-Through)

This block models a single-clock synchronous static memory built from 32-bit words, with a parameterized depth. Every address, data and control input is captured on the rising clock edge. An access is opened by one of two address strobes. The processor strobe always opens a read. The controller strobe opens either a read or a write, depending on the write inputs. Later beats of the same four-word group come from an internal 2-bit counter, which steps when the advance input is asserted. The group order is either linear or interleaved, chosen by a static mode input.

Reads follow flow-through timing. The word for a beat appears on the data output right after the edge that registers that beat. It is qualified by a drive flag, which takes the place of a tri-state buffer. The output enable acts at once, without waiting for a clock. A sleep input parks the memory. Stored contents are kept while asleep. When the memory wakes, address strobes are refused for a short lockout window, and each refused strobe is reported on an error pulse.

Top module: `sburst_sram`

## Requirements
- R1: With `wr_all_n`=1, lane i of the word (`byte_en_n[0]`→bits 7:0, `[1]`→15:8, `[2]`→23:16, `[3]`→31:24) is written only when `byte_wr_n`=0 and `byte_en_n[i]`=0. If `byte_wr_n`=1 or `byte_en_n`=4'hF, the beat is a read and the memory is unchanged.
- R2: `wr_all_n`=0 writes all four lanes, whatever `byte_wr_n` and `byte_en_n` hold.
- R3: An accepted `cpu_strobe_n`=0 always opens a read at `addr`, even when write inputs are asserted. A write then needs the write inputs on a later, strobe-free beat.
- R4: `ctl_strobe_n`=0 opens a beat at `addr`. The beat is a write or a read according to R1 and R2.
- R5: The chip enables are looked at only on an accepted strobe. The device is selected when `en_main_n`=0, `en_hi`=1 and `en_aux_n`=0. A deselecting strobe leaves the output undriven and blocks writes until the next selecting strobe. Changes on the enables between strobes have no effect.
- R6: `cpu_strobe_n`=0 while `en_main_n`=1 is ignored and acts as a strobe-free beat. Only `ctl_strobe_n` can therefore deselect.
- R7: When both strobes are high, `adv_n`=0 steps the beat counter, which wraps modulo 4. `adv_n`=1 holds the current beat. Either kind of beat may read or write.
- R8: Beat k of a group opened at base address b keeps the upper address bits of b. Its two low bits are (b+k) mod 4 when `linear_mode`=1, and b[1:0] XOR k when `linear_mode`=0.
- R9: After the edge that registers a selected read beat, `rdata` carries that beat's word and `rdata_drive`=1. After a write beat or a deselect, `rdata_drive`=0 and `rdata`=0.
- R10: `oe_n`=1 forces `rdata_drive`=0 and `rdata`=0 at once, with no clock edge needed.
- R11: An edge that samples `sleep`=1 ends any open access. While asleep the output is undriven and nothing is written. Contents are kept.
- R12: Once `sleep` is sampled low again, strobes at the first three rising edges are ignored. A strobe at the fourth edge is accepted.
- R13: `strobe_err` is high for exactly the cycle after an edge at which a strobe was ignored under R11 or R12. Otherwise it is low.
- R14: After reset `rdata_drive`=0, `strobe_err`=0, and no access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| linear_mode | input | 1 | Static group order: 1 linear, 0 interleaved |
| en_main_n | input | 1 | Primary chip enable, active low; also masks the processor strobe |
| en_hi | input | 1 | Secondary chip enable, active high |
| en_aux_n | input | 1 | Secondary chip enable, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, read-only start |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| addr | input | $clog2(DEPTH) | Word address |
| wr_all_n | input | 1 | Whole-word write, active low |
| byte_wr_n | input | 1 | Qualifier for per-lane writes, active low |
| byte_en_n | input | 4 | Per-lane write enables, active low |
| wdata | input | 32 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| rdata | output | 32 | Read data, zero when not driven |
| rdata_drive | output | 1 | High when `rdata` is being driven |
| strobe_err | output | 1 | Pulse flagging a strobe refused during sleep or wake lockout |

## Verification
The bench builds the block with DEPTH=16 and WAKE_CYCLES=3. At that depth every start address can be swept under both group orders, with a suspend beat and a full wrap through all four beats. The same build covers all sixteen lane-enable patterns on one word. With three lockout edges, each refused strobe and the first accepted one after wake-up can be checked one cycle at a time.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = 4;
    localparam int LANE_W = WORD_W / LANES;

    // Low two address bits of a beat inside its four-word group.
    function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       linear);
        return linear ? (base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/sburst_seq.sv
module sburst_seq #(
    parameter int AW = 6
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    cnt,
    input  logic          linear,
    output logic [AW-1:0] beat
);
    import sburst_pkg::*;

    generate
        if (AW > 2) begin : g_wide
            assign beat = {base[AW-1:2], beat_lo(base[1:0], cnt, linear)};
        end else begin : g_narrow
            assign beat = beat_lo(base[1:0], cnt, linear);
        end
    endgenerate

endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic [sburst_pkg::LANES-1:0]  we,
    input  logic [AW-1:0]                 waddr,
    input  logic [sburst_pkg::WORD_W-1:0] wdata,
    input  logic [AW-1:0]                 raddr,
    output logic [sburst_pkg::WORD_W-1:0] rword
);
    import sburst_pkg::*;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];

            always_ff @(posedge clk) begin
                if (we[g]) begin
                    mem[waddr] <= wdata[g*LANE_W +: LANE_W];
                end
            end

            assign rword[g*LANE_W +: LANE_W] = mem[raddr];
        end
    endgenerate

endmodule

// File: rtl/sburst_ctrl.sv
module sburst_ctrl #(
    parameter int AW          = 6,
    parameter int WAKE_CYCLES = 3,
    localparam int WW         = $clog2(WAKE_CYCLES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en_main_n,
    input  logic                         en_hi,
    input  logic                         en_aux_n,
    input  logic                         cpu_strobe_n,
    input  logic                         ctl_strobe_n,
    input  logic                         adv_n,
    input  logic [AW-1:0]                addr,
    input  logic                         wr_all_n,
    input  logic                         byte_wr_n,
    input  logic [sburst_pkg::LANES-1:0] byte_en_n,
    input  logic                         sleep,
    output logic                         active_q,
    output logic                         rd_q,
    output logic [AW-1:0]                base_q,
    output logic [1:0]                   cnt_q,
    output logic [AW-1:0]                base_d,
    output logic [1:0]                   cnt_d,
    output logic [sburst_pkg::LANES-1:0] wr_lanes,
    output logic                         lock,
    output logic                         err_q
);
    import sburst_pkg::*;

    typedef struct packed {
        logic          active;
        logic          rd;
        logic [AW-1:0] base;
        logic [1:0]    cnt;
        logic          asleep;
        logic [WW-1:0] wake;
        logic          err;
    } state_t;

    state_t st_d, st_q;
    logic [LANES-1:0] lanes;
    logic             wr_any;
    logic             cpu_ok;
    logic             start;
    logic             chip_sel;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;

        // Lane selection: whole-word write wins over per-lane enables
        if (!wr_all_n) begin
            lanes = '1;
        end else if (!byte_wr_n) begin
            lanes = ~byte_en_n;
        end else begin
            lanes = '0;
        end
        wr_any   = |lanes;

        lock     = sleep || st_q.asleep || (st_q.wake != '0);
        cpu_ok   = !cpu_strobe_n && !en_main_n;
        start    = cpu_ok || !ctl_strobe_n;
        chip_sel = !en_main_n && en_hi && !en_aux_n;

        // Sleep entry and wake-up lockout count
        st_d.asleep = sleep;
        if (sleep) begin
            st_d.wake = '0;
        end else if (st_q.asleep) begin
            st_d.wake = WW'(WAKE_CYCLES - 1);
        end else if (st_q.wake != '0) begin
            st_d.wake = st_q.wake - WW'(1);
        end

        if (lock) begin
            st_d.err = !cpu_strobe_n || !ctl_strobe_n;
            if (sleep) begin
                st_d.active = 1'b0;
            end
        end else if (start) begin
            st_d.active = chip_sel;
            st_d.base   = addr;
            st_d.cnt    = 2'd0;
            st_d.rd     = cpu_ok || !wr_any;
        end else if (st_q.active) begin
            if (!adv_n) begin
                st_d.cnt = st_q.cnt + 2'd1;
            end
            st_d.rd = !wr_any;
        end

        wr_lanes = (!lock && st_d.active && !st_d.rd) ? lanes : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_q = st_q.active;
    assign rd_q     = st_q.rd;
    assign base_q   = st_q.base;
    assign cnt_q    = st_q.cnt;
    assign base_d   = st_d.base;
    assign cnt_d    = st_d.cnt;
    assign err_q    = st_q.err;

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram #(
    parameter int DEPTH       = 64,
    parameter int WAKE_CYCLES = 3,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          linear_mode,
    input  logic          en_main_n,
    input  logic          en_hi,
    input  logic          en_aux_n,
    input  logic          cpu_strobe_n,
    input  logic          ctl_strobe_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_all_n,
    input  logic          byte_wr_n,
    input  logic [3:0]    byte_en_n,
    input  logic [31:0]   wdata,
    input  logic          oe_n,
    input  logic          sleep,
    output logic [31:0]   rdata,
    output logic          rdata_drive,
    output logic          strobe_err
);
    import sburst_pkg::*;

    logic             active_q;
    logic             rd_q;
    logic [AW-1:0]    base_q;
    logic [1:0]       cnt_q;
    logic [AW-1:0]    base_d;
    logic [1:0]       cnt_d;
    logic [LANES-1:0] wr_lanes;
    logic             lock;
    logic [AW-1:0]    beat_q;
    logic [AW-1:0]    beat_d;
    logic [WORD_W-1:0] rword;

    sburst_ctrl #(
        .AW          (AW),
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_main_n    (en_main_n),
        .en_hi        (en_hi),
        .en_aux_n     (en_aux_n),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .adv_n        (adv_n),
        .addr         (addr),
        .wr_all_n     (wr_all_n),
        .byte_wr_n    (byte_wr_n),
        .byte_en_n    (byte_en_n),
        .sleep        (sleep),
        .active_q     (active_q),
        .rd_q         (rd_q),
        .base_q       (base_q),
        .cnt_q        (cnt_q),
        .base_d       (base_d),
        .cnt_d        (cnt_d),
        .wr_lanes     (wr_lanes),
        .lock         (lock),
        .err_q        (strobe_err)
    );

    // Write address: the beat being registered at this edge
    sburst_seq #(.AW(AW)) u_seq_wr (
        .base   (base_d),
        .cnt    (cnt_d),
        .linear (linear_mode),
        .beat   (beat_d)
    );

    // Read address: the beat registered at the last edge
    sburst_seq #(.AW(AW)) u_seq_rd (
        .base   (base_q),
        .cnt    (cnt_q),
        .linear (linear_mode),
        .beat   (beat_q)
    );

    sburst_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .we    (wr_lanes),
        .waddr (beat_d),
        .wdata (wdata),
        .raddr (beat_q),
        .rword (rword)
    );

    assign rdata_drive = active_q && rd_q && !oe_n;
    assign rdata       = rdata_drive ? rword : '0;

endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic en_main_n,
    input logic en_hi,
    input logic en_aux_n,
    input logic cpu_strobe_n,
    input logic ctl_strobe_n,
    input logic oe_n,
    input logic sleep,
    input logic lock,
    input logic rdata_drive,
    input logic strobe_err
);

    AST_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_drive); // R10

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep) |-> !rdata_drive); // R11

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_err |-> $past(!cpu_strobe_n || !ctl_strobe_n)); // R13

    AST_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && !en_main_n && en_hi && !en_aux_n && !lock)
        |=> (rdata_drive || oe_n)); // R3

    AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_strobe_n && en_main_n && !lock) |=> !rdata_drive); // R5

endmodule

bind sburst_sram sburst_sram_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_main_n    (en_main_n),
    .en_hi        (en_hi),
    .en_aux_n     (en_aux_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .oe_n         (oe_n),
    .sleep        (sleep),
    .lock         (lock),
    .rdata_drive  (rdata_drive),
    .strobe_err   (strobe_err)
);

// File: tb/test_sburst_sram.sv
module test_sburst_sram;

    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          linear_mode;
    logic          en_main_n, en_hi, en_aux_n;
    logic          cpu_strobe_n, ctl_strobe_n, adv_n;
    logic [AW-1:0] addr;
    logic          wr_all_n, byte_wr_n;
    logic [3:0]    byte_en_n;
    logic [31:0]   wdata;
    logic          oe_n, sleep;
    logic [31:0]   rdata;
    logic          rdata_drive;
    logic          strobe_err;

    int checks = 0;
    int errors = 0;
    logic [31:0] sh [DEPTH];

    always #4 clk = ~clk;

    sburst_sram #(.DEPTH(DEPTH), .WAKE_CYCLES(3)) i_sburst_sram (
        .clk(clk), .rst_n(rst_n), .linear_mode(linear_mode),
        .en_main_n(en_main_n), .en_hi(en_hi), .en_aux_n(en_aux_n),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .adv_n(adv_n), .addr(addr), .wr_all_n(wr_all_n),
        .byte_wr_n(byte_wr_n), .byte_en_n(byte_en_n), .wdata(wdata),
        .oe_n(oe_n), .sleep(sleep), .rdata(rdata),
        .rdata_drive(rdata_drive), .strobe_err(strobe_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [31:0] exp);
        chk({tag, " drive"}, 32'(rdata_drive), 32'd1);
        chk({tag, " data"}, rdata, exp);
    endtask

    task automatic chk_off(input string tag);
        chk({tag, " drive"}, 32'(rdata_drive), 32'd0);
        chk({tag, " data"}, rdata, 32'd0);
    endtask

    task automatic idle();
        en_main_n = 0; en_hi = 1; en_aux_n = 0;
        cpu_strobe_n = 1; ctl_strobe_n = 1; adv_n = 1;
        wr_all_n = 1; byte_wr_n = 1; byte_en_n = 4'hF;
        wdata = '0; oe_n = 0; sleep = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic int beat(input int b, input int k, input bit lin);
        int lo;
        lo = lin ? ((b + k) & 3) : ((b & 3) ^ (k & 3));
        return (b & ~3) | lo;
    endfunction

    task automatic ctl_read(input int a, input string tag);
        idle(); ctl_strobe_n = 0; addr = AW'(a);
        step();
        chk_rd(tag, sh[a]);
        idle();
    endtask

    initial begin
        idle();
        linear_mode = 1; addr = '0; rst_n = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R14: reset state
        chk("R14 drive", 32'(rdata_drive), 32'd0);
        chk("R14 err", 32'(strobe_err), 32'd0);

        // R4/R2/R9: fill with whole-word writes started by the controller strobe
        for (int a = 0; a < DEPTH; a++) begin
            idle(); ctl_strobe_n = 0; addr = AW'(a); wr_all_n = 0;
            wdata = (32'(a) * 32'h0103_0507) ^ 32'h5A5A_0000;
            sh[a] = wdata;
            step();
            chk_off("R9 write beat undriven");
        end
        for (int a = 0; a < DEPTH; a++) ctl_read(a, "R4 single read");

        // R7/R8: burst sweep, both orders, every start, one suspend, wrap
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < DEPTH; b++) begin
                idle(); linear_mode = m[0]; cpu_strobe_n = 0; addr = AW'(b);
                step();
                chk_rd("R8 beat0", sh[beat(b, 0, m[0])]);
                idle(); adv_n = 0; step();
                chk_rd("R8 beat1", sh[beat(b, 1, m[0])]);
                idle(); adv_n = 1; step();
                chk_rd("R7 suspend", sh[beat(b, 1, m[0])]);
                idle(); adv_n = 0; step();
                chk_rd("R8 beat2", sh[beat(b, 2, m[0])]);
                step();
                chk_rd("R8 beat3", sh[beat(b, 3, m[0])]);
                step();
                chk_rd("R7 wrap", sh[beat(b, 0, m[0])]);
            end
        end
        linear_mode = 1;

        // R1: every lane-enable pattern on word 5
        for (int p = 0; p < 16; p++) begin
            logic [31:0] nd;
            logic [31:0] old;
            nd  = 32'hDEAD_BEEF + 32'(p) * 32'h1111_1111;
            old = sh[5];
            idle(); ctl_strobe_n = 0; addr = 4'd5; byte_wr_n = 0;
            byte_en_n = 4'(p); wdata = nd;
            step();
            if (p == 15) begin
                chk_rd("R1 no lane is read", old);
            end else begin
                chk_off("R1 lane write undriven");
                for (int l = 0; l < 4; l++)
                    if (!p[l]) sh[5][l*8 +: 8] = nd[l*8 +: 8];
            end
            ctl_read(5, "R1 lane readback");
        end
        // R1: byte_wr_n high means read even with lanes enabled
        idle(); ctl_strobe_n = 0; addr = 4'd5; byte_en_n = 4'h0; wdata = 32'h0;
        step();
        chk_rd("R1 qualifier off", sh[5]);
        ctl_read(5, "R1 unchanged");
        // R2: whole-word write overrides lane inputs
        idle(); ctl_strobe_n = 0; addr = 4'd5; wr_all_n = 0; byte_wr_n = 1;
        byte_en_n = 4'hF; wdata = 32'h1234_5678; sh[5] = wdata;
        step();
        chk_off("R2 write beat");
        ctl_read(5, "R2 readback");

        // R3: processor strobe reads despite write inputs; write on next beat
        idle(); cpu_strobe_n = 0; addr = 4'd8; wr_all_n = 0; wdata = 32'hBAD0_BAD0;
        step();
        chk_rd("R3 forced read", sh[8]);
        idle(); adv_n = 0; wr_all_n = 0; wdata = 32'h0F0F_1234; sh[9] = wdata;
        step();
        chk_off("R3 continue write");
        ctl_read(8, "R3 start word unchanged");
        ctl_read(9, "R3 continue word written");

        // R6: blocked processor strobe acts as continue
        ctl_read(2, "R6 open");
        idle(); cpu_strobe_n = 0; en_main_n = 1; addr = 4'd12; adv_n = 0;
        step();
        chk_rd("R6 blocked strobe continues", sh[3]);
        // R5: enables ignored between strobes
        idle(); en_hi = 0; adv_n = 0;
        step();
        chk_rd("R5 enables not sampled", sh[0]);
        // R5: controller strobe deselects
        idle(); ctl_strobe_n = 0; en_main_n = 1;
        step();
        chk_off("R5 deselect");
        idle(); adv_n = 0; step();
        chk_off("R5 stays deselected");
        idle(); cpu_strobe_n = 0; en_aux_n = 1; addr = 4'd1; step();
        chk_off("R5 aux enable deselects");
        idle(); ctl_strobe_n = 0; en_hi = 0; addr = 4'd4; wr_all_n = 0;
        wdata = 32'hFFFF_0000; step();
        chk_off("R5 deselected write");
        ctl_read(4, "R5 no write while deselected");

        // R10: output enable acts without a clock
        ctl_read(7, "R10 open");
        #1 oe_n = 1;
        #1 chk_off("R10 oe high");
        oe_n = 0;
        #1 chk_rd("R10 oe low", sh[7]);

        // R11/R12/R13: sleep, retention, lockout
        ctl_read(6, "R11 open");
        idle(); sleep = 1; step();
        chk_off("R11 asleep");
        chk("R13 no err", 32'(strobe_err), 32'd0);
        idle(); sleep = 1; cpu_strobe_n = 0; addr = 4'd3; step();
        chk_off("R11 strobe in sleep");
        chk("R13 err in sleep", 32'(strobe_err), 32'd1);
        for (int w = 0; w < 3; w++) begin
            idle(); ctl_strobe_n = 0; addr = 4'd6; step();
            chk_off("R12 lockout");
            chk("R13 err in lockout", 32'(strobe_err), 32'd1);
        end
        idle(); ctl_strobe_n = 0; addr = 4'd6; step();
        chk_rd("R12 accepted after lockout", sh[6]);
        chk("R13 err cleared", 32'(strobe_err), 32'd0);
        idle(); step();
        chk_rd("R11 retained", sh[6]);
        chk("R13 err stays low", 32'(strobe_err), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule